// File: doc/BRIEF.md
# Fixed-Point Compare Unit with Condition-Register Merge

This unit carries out the four integer compare operations of a 64-bit load/store instruction set. It takes one 32-bit instruction word, two 64-bit register operands, the current 32-bit condition register and the summary-overflow bit. From the instruction word it decodes the operation, the width, the destination field and the 16-bit immediate.

The comparison is either signed or unsigned. It uses either the full 64 bits of the operands or only their low 32 bits. The outcome is a 4-bit code, which is written into one of the eight 4-bit fields of the condition register. The other seven fields pass through unchanged.

Each cycle the unit presents a new condition-register value and a flag that tells whether the word was a compare. Both outputs come from a register stage, so the result appears one clock after the inputs. A word that is not a compare clears the flag and returns the condition register as it was.

Top module: `fxcmp_unit`

## Requirements
- R1: The primary opcode is bits 31:26. Value 11 selects a signed immediate compare and value 10 selects an unsigned immediate compare. Value 31 selects the register pair, with the sub-opcode in bits 10:1: 0 means signed and 32 means unsigned. Each of these four encodings raises `out_valid`.
- R2: Any other encoding drives `out_valid` low and returns `cr_in` unchanged on `cr_out`.
- R3: When bit 21 is 1, all 64 bits of both operands take part in the comparison.
- R4: When bit 21 is 0, only bits 31:0 of each operand are compared, and the upper halves have no effect. A signed compare reads those bits as a two's-complement 32-bit value; an unsigned compare reads them as an unsigned 32-bit value.
- R5: The signed immediate form compares `opa` with bits 15:0 of the instruction, sign-extended.
- R6: The unsigned immediate form compares `opa` with bits 15:0 of the instruction, zero-extended.
- R7: The 4-bit code is {less, greater, equal, overflow} from bit 3 down to bit 0. Exactly one of the three upper bits is set.
- R8: The lowest bit of the code equals `so_in`.
- R9: Bits 25:23 select the destination field n, which occupies `cr_out` bits 31-4n down to 28-4n. The other fields equal `cr_in`.
- R10: `rst` is synchronous and active high, and it clears `cr_out` and `out_valid`. Outside reset, the outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word |
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand (register forms only) |
| cr_in | input | 32 | Current condition register |
| so_in | input | 1 | Summary-overflow bit |
| out_valid | output | 1 | High when the sampled word was a compare |
| cr_out | output | 32 | Updated condition register |

## Verification
The bench uses operands whose upper halves differ while their lower halves match. A unit that ignored the width bit would report equal in 64-bit mode, or unequal in 32-bit mode. The same negative bit patterns go through both signed and unsigned compares, so swapping the extension kind flips less and greater.

The immediates 0x8000 and 0x7FFF are also used. A wrong immediate extension shows up as a result that is off by sign. Every destination field is written at least once, which exposes a reversed or shifted field position through damage to a neighbouring field. Non-compare encodings check that nothing is written.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int SEL_W  = 3;

  localparam logic [5:0] PO_IMM_SIGNED   = 6'd11;
  localparam logic [5:0] PO_IMM_UNSIGNED = 6'd10;
  localparam logic [5:0] PO_REG_GROUP    = 6'd31;
  localparam logic [9:0] SUB_SIGNED      = 10'd0;
  localparam logic [9:0] SUB_UNSIGNED    = 10'd32;

  typedef enum logic [1:0] {
    K_REG_S,
    K_REG_U,
    K_IMM_S,
    K_IMM_U
  } cmp_kind_e;

  typedef struct packed {
    logic             ok;
    cmp_kind_e        kind;
    logic             wide;
    logic [SEL_W-1:0] sel;
    logic [IMM_W-1:0] imm;
  } cmp_dec_t;
endpackage

// File: rtl/cmpu_decode.sv
module cmpu_decode
  import cmpu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output cmp_dec_t          dec
);
  logic [5:0] po;
  logic [9:0] sub;
  logic       unused_bits;

  assign po          = insn[31:26];
  assign sub         = insn[10:1];
  assign unused_bits = ^{insn[22], insn[20:16], insn[0]};

  always_comb begin
    dec.ok   = 1'b1;
    dec.kind = K_REG_S;
    dec.wide = insn[21];
    dec.sel  = insn[25:23];
    dec.imm  = insn[IMM_W-1:0];
    case (po)
      PO_IMM_SIGNED:   dec.kind = K_IMM_S;
      PO_IMM_UNSIGNED: dec.kind = K_IMM_U;
      PO_REG_GROUP: begin
        if (sub == SUB_SIGNED)        dec.kind = K_REG_S;
        else if (sub == SUB_UNSIGNED) dec.kind = K_REG_U;
        else                          dec.ok   = 1'b0;
      end
      default: dec.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpu_compare.sv
module cmpu_compare
  import cmpu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  cmp_kind_e        kind,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic             so,
  output logic [3:0]       code
);
  localparam int EXT = XLEN + 1;

  logic            sgn, use_imm;
  logic [XLEN-1:0] imm_x, rhs_full, lhs_sel, rhs_sel;
  logic [EXT-1:0]  lx, rx;
  logic            lt, gt, eq;

  always_comb begin
    sgn      = (kind == K_REG_S) || (kind == K_IMM_S);
    use_imm  = (kind == K_IMM_S) || (kind == K_IMM_U);
    imm_x    = {{(XLEN-IMM_W){sgn & imm[IMM_W-1]}}, imm};
    rhs_full = use_imm ? imm_x : opb;
    if (wide) begin
      lhs_sel = opa;
      rhs_sel = rhs_full;
    end else begin
      lhs_sel = {{(XLEN-HALF){sgn & opa[HALF-1]}}, opa[HALF-1:0]};
      rhs_sel = {{(XLEN-HALF){sgn & rhs_full[HALF-1]}}, rhs_full[HALF-1:0]};
    end
    lx   = {sgn & lhs_sel[XLEN-1], lhs_sel};
    rx   = {sgn & rhs_sel[XLEN-1], rhs_sel};
    lt   = $signed(lx) < $signed(rx);
    gt   = $signed(lx) > $signed(rx);
    eq   = (lx == rx);
    code = {lt, gt, eq, so};
  end
endmodule

// File: rtl/cmpu_merge.sv
module cmpu_merge #(
  parameter int CRW   = 32,
  parameter int FW    = 4,
  parameter int NF    = CRW / FW,
  parameter int FLD_W = $clog2(NF)
) (
  input  logic [CRW-1:0]   cr_in,
  input  logic [FLD_W-1:0] sel,
  input  logic [FW-1:0]    code,
  input  logic             en,
  output logic [CRW-1:0]   cr_out
);
  for (genvar g = 0; g < NF; g++) begin : g_field
    localparam int HI = CRW - 1 - g * FW;
    assign cr_out[HI -: FW] = (en && sel == FLD_W'(g)) ? code : cr_in[HI -: FW];
  end
endmodule

// File: rtl/fxcmp_unit.sv
module fxcmp_unit
  import cmpu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int HALF    = 32,
  parameter int CRW     = 32,
  parameter int FW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [CRW-1:0]    cr_in,
  input  logic              so_in,
  output logic              out_valid,
  output logic [CRW-1:0]    cr_out
);
  localparam int NF    = CRW / FW;
  localparam int FLD_W = $clog2(NF);

  cmp_dec_t       dec;
  logic [FW-1:0]  code;
  logic [CRW-1:0] cr_next;

  cmpu_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  cmpu_compare #(.XLEN(XLEN), .HALF(HALF)) u_cmp (
    .kind (dec.kind),
    .wide (dec.wide),
    .imm  (dec.imm),
    .opa  (opa),
    .opb  (opb),
    .so   (so_in),
    .code (code)
  );

  cmpu_merge #(.CRW(CRW), .FW(FW)) u_mrg (
    .cr_in  (cr_in),
    .sel    (FLD_W'(dec.sel)),
    .code   (code),
    .en     (dec.ok),
    .cr_out (cr_next)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        cr_out    <= '0;
      end else begin
        out_valid <= dec.ok;
        cr_out    <= cr_next;
      end
    end
  end else begin : g_comb
    assign out_valid = dec.ok;
    assign cr_out    = cr_next;
  end
endmodule

// File: rtl/fxcmp_unit_chk.sv
module fxcmp_unit_chk #(
  parameter int CRW     = 32,
  parameter int FW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic [31:0]    insn,
  input logic [CRW-1:0] cr_in,
  input logic           so_in,
  input logic           out_valid,
  input logic [CRW-1:0] cr_out
);
  if (REG_OUT) begin : g_chk
    logic           started;
    logic [31:0]    insn_q;
    logic [CRW-1:0] cr_q;
    logic           so_q;
    logic           exp_ok;
    logic [CRW-1:0] mask;
    logic [FW-1:0]  cur_code;
    int             shamt;

    always_ff @(posedge clk) begin
      if (rst) begin
        started <= 1'b0;
        insn_q  <= '0;
        cr_q    <= '0;
        so_q    <= 1'b0;
      end else begin
        started <= 1'b1;
        insn_q  <= insn;
        cr_q    <= cr_in;
        so_q    <= so_in;
      end
    end

    always_comb begin
      exp_ok = (insn_q[31:26] == 6'd10) || (insn_q[31:26] == 6'd11) ||
               ((insn_q[31:26] == 6'd31) &&
                ((insn_q[10:1] == 10'd0) || (insn_q[10:1] == 10'd32)));
      shamt    = CRW - FW - FW * int'(insn_q[25:23]);
      mask     = {{(CRW-FW){1'b0}}, {FW{1'b1}}} << shamt;
      cur_code = FW'(cr_out >> shamt);
    end

    p_valid_decode_r1: assert property (@(posedge clk) disable iff (rst)
      started |-> (out_valid == exp_ok));

    p_hold_invalid_r2: assert property (@(posedge clk) disable iff (rst)
      (started && !out_valid) |-> (cr_out == cr_q));

    p_one_hot_r7: assert property (@(posedge clk) disable iff (rst)
      (started && out_valid) |-> ($countones(cur_code[FW-1:1]) == 1));

    p_so_copy_r8: assert property (@(posedge clk) disable iff (rst)
      (started && out_valid) |-> (cur_code[0] == so_q));

    p_other_fields_r9: assert property (@(posedge clk) disable iff (rst)
      (started && out_valid) |-> ((cr_out & ~mask) == (cr_q & ~mask)));
  end else begin : g_none
    logic unused_in;
    assign unused_in = ^{clk, rst, insn, cr_in, so_in, out_valid, cr_out};
  end
endmodule

bind fxcmp_unit fxcmp_unit_chk #(.CRW(CRW), .FW(FW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn      (insn),
  .cr_in     (cr_in),
  .so_in     (so_in),
  .out_valid (out_valid),
  .cr_out    (cr_out)
);

// File: tb/fxcmp_unit_bench.sv
`timescale 1ns/100ps
module fxcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [31:0] cr_in = '0;
  logic        so_in = 1'b0;
  logic        out_valid;
  logic [31:0] cr_out;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  fxcmp_unit u_fxcmp_unit (
    .clk(clk), .rst(rst), .insn(insn), .opa(opa), .opb(opb),
    .cr_in(cr_in), .so_in(so_in), .out_valid(out_valid), .cr_out(cr_out)
  );

  function automatic logic [31:0] mk_reg(input bit sgn, input bit wide, input logic [2:0] f);
    return {6'd31, f, 1'b0, wide, 10'd0, (sgn ? 10'd0 : 10'd32), 1'b0};
  endfunction

  function automatic logic [31:0] mk_imm(input bit sgn, input bit wide, input logic [2:0] f,
                                         input logic [15:0] imm);
    return {(sgn ? 6'd11 : 6'd10), f, 1'b0, wide, 5'd0, imm};
  endfunction

  function automatic logic [32:0] model(input logic [31:0] i, input logic [63:0] a,
                                        input logic [63:0] b, input logic [31:0] c, input logic s);
    logic ok, sgn, imm_form, lt, gt;
    logic [63:0] r;
    logic [31:0] res;
    logic [3:0]  cd;
    int fld;
    ok = 1'b1; sgn = 1'b0; imm_form = 1'b0;
    if (i[31:26] == 6'd11) begin sgn = 1; imm_form = 1; end
    else if (i[31:26] == 6'd10) begin sgn = 0; imm_form = 1; end
    else if (i[31:26] == 6'd31 && i[10:1] == 10'd0) sgn = 1;
    else if (i[31:26] == 6'd31 && i[10:1] == 10'd32) sgn = 0;
    else ok = 1'b0;
    if (!ok) return {1'b0, c};
    if (imm_form) r = sgn ? 64'($signed(i[15:0])) : {48'd0, i[15:0]};
    else r = b;
    if (i[21]) begin
      lt = sgn ? ($signed(a) < $signed(r)) : (a < r);
      gt = sgn ? ($signed(a) > $signed(r)) : (a > r);
    end else begin
      lt = sgn ? ($signed(a[31:0]) < $signed(r[31:0])) : (a[31:0] < r[31:0]);
      gt = sgn ? ($signed(a[31:0]) > $signed(r[31:0])) : (a[31:0] > r[31:0]);
    end
    cd  = {lt, gt, !(lt || gt), s};
    fld = int'(i[25:23]);
    res = c;
    for (int k = 0; k < 32; k++)
      if (k / 4 == 7 - fld) res[k] = cd[k % 4];
    return {1'b1, res};
  endfunction

  task automatic run(input string tag, input logic [31:0] i, input logic [63:0] a,
                     input logic [63:0] b, input logic [31:0] c, input logic s);
    logic [32:0] e;
    @(negedge clk);
    insn = i; opa = a; opb = b; cr_in = c; so_in = s;
    e = model(i, a, b, c, s);
    @(negedge clk);
    n_chk++;
    if ({out_valid, cr_out} !== e) begin
      n_err++;
      $display("FAIL %s: got valid=%0b cr=%h, expected valid=%0b cr=%h",
               tag, out_valid, cr_out, e[32], e[31:0]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] i;
    logic [63:0] a, b;
    void'($urandom(32'd777));
    insn = mk_reg(1, 1, 3'd2); opa = 64'd5; opb = 64'd9; cr_in = 32'hFFFF_FFFF; so_in = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || cr_out !== 32'h0) begin
      n_err++;
      $display("FAIL R10 reset: got valid=%0b cr=%h, expected valid=0 cr=00000000", out_valid, cr_out);
    end
    rst = 1'b0;

    // R3 R4: upper halves differ, lower halves equal
    run("R4 narrow ignores upper", mk_reg(1, 0, 3'd0), 64'h0000_0001_1234_5678, 64'h7FFF_0000_1234_5678, 32'h0, 0);
    run("R3 wide sees upper",      mk_reg(1, 1, 3'd0), 64'h0000_0001_1234_5678, 64'h7FFF_0000_1234_5678, 32'h0, 0);
    run("R3 wide unsigned upper",  mk_reg(0, 1, 3'd1), 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 32'h0, 0);
    // R4: same pattern signed vs unsigned
    run("R4 signed negative",      mk_reg(1, 0, 3'd3), 64'h0000_0000_FFFF_FFFF, 64'd1, 32'hA5A5_A5A5, 0);
    run("R4 unsigned same bits",   mk_reg(0, 0, 3'd3), 64'h0000_0000_FFFF_FFFF, 64'd1, 32'hA5A5_A5A5, 0);
    // R5 R6 immediates
    run("R5 imm 0x8000 signed eq",   mk_imm(1, 1, 3'd4, 16'h8000), 64'hFFFF_FFFF_FFFF_8000, 64'd0, 32'h0, 1);
    run("R5 imm 0x8000 narrow",      mk_imm(1, 0, 3'd4, 16'h8000), 64'h1234_5678_FFFF_8000, 64'd0, 32'h0, 0);
    run("R6 imm 0x8000 unsigned",    mk_imm(0, 1, 3'd5, 16'h8000), 64'h0000_0000_0000_8000, 64'd0, 32'h0, 0);
    run("R6 imm 0x8000 vs negative", mk_imm(0, 1, 3'd5, 16'h8000), 64'hFFFF_FFFF_FFFF_8000, 64'd0, 32'h0, 0);
    run("R5 imm 0x7FFF signed",      mk_imm(1, 0, 3'd6, 16'h7FFF), 64'h0000_0000_0000_8000, 64'd0, 32'h0, 0);
    run("R6 imm 0x7FFF unsigned",    mk_imm(0, 0, 3'd6, 16'h7FFF), 64'h0000_0000_0000_7FFF, 64'd0, 32'h0, 1);
    // R8 R9: every field, with SO set and cleared
    for (int f = 0; f < 8; f++) begin
      run("R9 field walk", mk_reg(0, 1, 3'(f)), 64'd3, 64'd7, 32'h1234_5678, f[0]);
      run("R8 field walk", mk_imm(1, 1, 3'(f), 16'hFFFF), 64'd0, 64'd0, 32'hFEDC_BA98, ~f[0]);
    end
    // R2 non-compare encodings
    run("R2 bad sub-opcode", {6'd31, 3'd1, 1'b0, 1'b1, 10'd0, 10'd5, 1'b0}, 64'd1, 64'd2, 32'hCAFE_F00D, 1);
    run("R2 other opcode",   {6'd12, 3'd2, 1'b0, 1'b1, 5'd0, 16'h0001}, 64'd1, 64'd2, 32'h0BAD_BEEF, 0);

    // Random mix: R1 R3 R4 R5 R6 R7 R8 R9 R2
    for (int n = 0; n < 1500; n++) begin
      int k, m;
      k = $urandom_range(0, 4);
      m = $urandom_range(0, 3);
      a = {$urandom, $urandom};
      case (m)
        0: b = {$urandom, $urandom};
        1: b = a;
        2: b = {~a[63:32], a[31:0]};
        default: begin b = {$urandom, $urandom}; a = 64'($signed(16'($urandom))); end
      endcase
      case (k)
        0: i = mk_reg(1, 1'($urandom), 3'($urandom));
        1: i = mk_reg(0, 1'($urandom), 3'($urandom));
        2: i = mk_imm(1, 1'($urandom), 3'($urandom), (m == 1) ? a[15:0] : 16'($urandom));
        3: i = mk_imm(0, 1'($urandom), 3'($urandom), (m == 1) ? a[15:0] : 16'($urandom));
        default: begin
          i = $urandom;
          if (i[31:26] == 6'd10 || i[31:26] == 6'd11) i[31:26] = 6'd12;
          if (i[31:26] == 6'd31 && (i[10:1] == 10'd0 || i[10:1] == 10'd32)) i[10:1] = 10'd5;
        end
      endcase
      run("random R1 R2 R7", i, a, b, $urandom, 1'($urandom));
    end

    // R10 reset mid-stream
    @(negedge clk);
    rst = 1'b1; insn = mk_reg(1, 1, 3'd0); cr_in = 32'hFFFF_FFFF;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || cr_out !== 32'h0) begin
      n_err++;
      $display("FAIL R10 reset mid-run: got valid=%0b cr=%h, expected valid=0 cr=00000000", out_valid, cr_out);
    end
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule